// File: doc/BRIEF.md
# Quadrature Encoder Compare and Event Unit

This block sits beside the counters of a quadrature encoder interface and turns their activity into four events: a position match, a stall (no counted edge for too long), a rising edge on the home input and a rising edge on the index input. The counters themselves are outside the block. It sees their current values, the count direction and a one-cycle strobe for each counted edge. It latches every event into a sticky status word that software clears by writing ones.

The position match compares the phase count with a programmed value. It can also require the revolution (index) count to equal its own compare value, and it can require a given rotation direction. Each of these extra conditions has its own disable. The match raises its event once each time the condition goes from false to true.

Four 4-bit enable masks share the status bit layout. Three of them gate level outputs: an interrupt line, a DMA request and an output trigger. The fourth selects which new events emit a one-cycle strobe that tells the counter block to load its read registers. All control and status pins are plain levels or strobes. The block carries no streamed data, so it has no valid/ready handshake.

Top module: `enc_event_unit`

## Requirements
- R1: In `status_o`, bit 31 is the stall (watchdog) event, bit 30 is home, bit 29 is position match and bit 28 is index. Bits 27:0 always read 0. Every mask and clear input is indexed [31:28] with the same meaning per bit. After reset, the status and all outputs are 0.
- R2: With `clr_wr_i` high for one cycle, each status bit whose `clr_data_i` bit is 1 reads 0 from the next cycle on. A bit whose `clr_data_i` bit is 0 keeps its value.
- R3: If an event occurs in the same cycle that its status bit is written with 1, the bit stays set.
- R4: `irq_o` is high while any status bit in 31:28 is set together with the same bit of `irq_mask_i`. `dma_req_o` follows the same rule with `dma_mask_i`, and `trig_o` with `trg_mask_i`. The three masks act independently.
- R5: `rd_load_o` is high for exactly the one cycle after an event whose bit is set in `rd_mask_i`. This holds even when that status bit was already set. Events whose bit is clear in `rd_mask_i` give no pulse.
- R6: The position-match event needs `ph_cnt_i == ph_cmp_i`. Unless `z_cmp_dis_i` is 1, it also needs `z_cnt_i == z_cmp_i`. It fires on the first cycle the full condition holds, and it does not fire again while the condition stays true.
- R7: Direction encoding is 0 = positive and 1 = negative. With `dir_dis_i` = 0, a match also needs `dir_i == dir_req_i`. With `dir_dis_i` = 1, direction is ignored.
- R8: With `wdg_en_i` = 1 and `wdg_timeout_i` = T ≥ 1, the stall bit sets on the T-th clock edge after the last edge that sampled `cnt_step_i` high. It fires only once until the next step. With T = 0, or with `wdg_en_i` = 0, it never fires.
- R9: A rising edge on `home_i` sets bit 30, and a rising edge on `z_index_i` sets bit 28, both on the edge where the new level is first sampled. Level alone gives no repeat events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ph_cnt_i | input | PH_W | Current phase count |
| z_cnt_i | input | Z_W | Current revolution (index) count |
| cnt_step_i | input | 1 | One-cycle strobe per counted encoder edge |
| dir_i | input | 1 | Current rotation direction, 0 positive, 1 negative |
| home_i | input | 1 | Home sensor level |
| z_index_i | input | 1 | Index pulse level |
| ph_cmp_i | input | PH_W | Phase compare value |
| z_cmp_i | input | Z_W | Revolution compare value |
| z_cmp_dis_i | input | 1 | 1 = revolution count excluded from match |
| dir_req_i | input | 1 | Required direction for a match |
| dir_dis_i | input | 1 | 1 = direction ignored |
| wdg_en_i | input | 1 | Stall watchdog enable |
| wdg_timeout_i | input | TO_W | Stall timeout in cycles |
| clr_wr_i | input | 1 | Status clear write strobe |
| clr_data_i | input | 4 ([31:28]) | Write-one-to-clear bits |
| irq_mask_i | input | 4 ([31:28]) | Interrupt enable mask |
| dma_mask_i | input | 4 ([31:28]) | DMA request enable mask |
| trg_mask_i | input | 4 ([31:28]) | Output trigger enable mask |
| rd_mask_i | input | 4 ([31:28]) | Read-load strobe enable mask |
| status_o | output | 32 | Sticky event status |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |
| trig_o | output | 1 | Output trigger |
| rd_load_o | output | 1 | One-cycle read-load strobe |

## Verification
A bad edge register in the position or input detectors shows in one of two ways on the edge after the stimulus. Either a status bit fails to set, or a held condition sets it again after a clear. The sweep over match inputs exposes both within one cycle. A stall counter that is off by one, or that fails to saturate, moves the cycle at which bit 31 appears, or makes it reappear after a clear. The bench counts edges from the last step and compares that count exactly. A wrong mask routing shows at once on the combinational outputs, because every status pattern is crossed with every mask value.

// File: rtl/enc_evt_pkg.sv
package enc_evt_pkg;
  localparam int STAT_W   = 32;
  localparam int NUM_EVT  = 4;
  localparam int EVT_LSB  = 28;
  localparam int N_LEVEL  = 3;   // irq, dma, trigger

  // Index into the internal event vector; status bit = EVT_LSB + index
  typedef enum logic [1:0] {
    EV_ZIDX   = 2'd0,
    EV_PMATCH = 2'd1,
    EV_HOME   = 2'd2,
    EV_STALL  = 2'd3
  } evt_idx_e;

  typedef enum logic {
    DIR_POS = 1'b0,
    DIR_NEG = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/enc_rise_det.sv
module enc_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/enc_pos_match.sv
module enc_pos_match #(
  parameter int PH_W = 16,
  parameter int Z_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ph_cnt_i,
  input  logic [Z_W-1:0]  z_cnt_i,
  input  logic            dir_i,
  input  logic [PH_W-1:0] ph_cmp_i,
  input  logic [Z_W-1:0]  z_cmp_i,
  input  logic            z_cmp_dis_i,
  input  logic            dir_req_i,
  input  logic            dir_dis_i,
  output logic            hit_o
);
  logic ph_eq, z_ok, dir_ok, cond, cond_q;

  assign ph_eq  = (ph_cnt_i == ph_cmp_i);
  assign z_ok   = z_cmp_dis_i | (z_cnt_i == z_cmp_i);
  assign dir_ok = dir_dis_i | (dir_i == dir_req_i);
  assign cond   = ph_eq & z_ok & dir_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign hit_o = cond & ~cond_q;
endmodule

// File: rtl/enc_stall_wdog.sv
module enc_stall_wdog #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [TO_W-1:0] timeout_i,
  input  logic            step_i,
  output logic            expire_o
);
  logic [TO_W-1:0] idle_q;
  logic            armed;

  assign armed    = en_i & ~step_i & (timeout_i != '0);
  assign expire_o = armed & (idle_q == timeout_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     idle_q <= '0;
    else if (!en_i || step_i)       idle_q <= '0;
    else if (idle_q < timeout_i)    idle_q <= idle_q + 1'b1;
  end
endmodule

// File: rtl/enc_evt_status.sv
module enc_evt_status
  import enc_evt_pkg::*;
#(
  parameter int NE = NUM_EVT,
  parameter int NL = N_LEVEL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NE-1:0]      evt_i,
  input  logic               clr_wr_i,
  input  logic [NE-1:0]      clr_bits_i,
  input  logic [NL*NE-1:0]   lvl_mask_i,
  input  logic [NE-1:0]      rd_mask_i,
  output logic [NE-1:0]      st_o,
  output logic [NL-1:0]      lvl_o,
  output logic               rd_pulse_o
);
  logic [NE-1:0] st_q, clr_eff;

  assign clr_eff = clr_wr_i ? clr_bits_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= '0;
      rd_pulse_o <= 1'b0;
    end else begin
      st_q       <= (st_q & ~clr_eff) | evt_i;
      rd_pulse_o <= |(evt_i & rd_mask_i);
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_lvl
    assign lvl_o[g] = |(st_q & lvl_mask_i[g*NE +: NE]);
  end

  assign st_o = st_q;
endmodule

// File: rtl/enc_event_unit.sv
module enc_event_unit
  import enc_evt_pkg::*;
#(
  parameter int PH_W = 16,
  parameter int Z_W  = 16,
  parameter int TO_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PH_W-1:0]             ph_cnt_i,
  input  logic [Z_W-1:0]              z_cnt_i,
  input  logic                        cnt_step_i,
  input  logic                        dir_i,
  input  logic                        home_i,
  input  logic                        z_index_i,
  input  logic [PH_W-1:0]             ph_cmp_i,
  input  logic [Z_W-1:0]              z_cmp_i,
  input  logic                        z_cmp_dis_i,
  input  logic                        dir_req_i,
  input  logic                        dir_dis_i,
  input  logic                        wdg_en_i,
  input  logic [TO_W-1:0]             wdg_timeout_i,
  input  logic                        clr_wr_i,
  input  logic [31:28]                clr_data_i,
  input  logic [31:28]                irq_mask_i,
  input  logic [31:28]                dma_mask_i,
  input  logic [31:28]                trg_mask_i,
  input  logic [31:28]                rd_mask_i,
  output logic [31:0]                 status_o,
  output logic                        irq_o,
  output logic                        dma_req_o,
  output logic                        trig_o,
  output logic                        rd_load_o
);
  localparam int LOW_W = EVT_LSB;

  logic [1:0]           edge_rise;
  logic                 pm_hit, wd_expire;
  logic [NUM_EVT-1:0]   evt_vec, st_vec;
  logic [N_LEVEL-1:0]   lvl;

  enc_rise_det #(.N(2)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({home_i, z_index_i}),
    .rise_o (edge_rise)
  );

  enc_pos_match #(.PH_W(PH_W), .Z_W(Z_W)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph_cnt_i    (ph_cnt_i),
    .z_cnt_i     (z_cnt_i),
    .dir_i       (dir_i),
    .ph_cmp_i    (ph_cmp_i),
    .z_cmp_i     (z_cmp_i),
    .z_cmp_dis_i (z_cmp_dis_i),
    .dir_req_i   (dir_req_i),
    .dir_dis_i   (dir_dis_i),
    .hit_o       (pm_hit)
  );

  enc_stall_wdog #(.TO_W(TO_W)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (wdg_en_i),
    .timeout_i (wdg_timeout_i),
    .step_i    (cnt_step_i),
    .expire_o  (wd_expire)
  );

  always_comb begin
    evt_vec            = '0;
    evt_vec[EV_ZIDX]   = edge_rise[0];
    evt_vec[EV_PMATCH] = pm_hit;
    evt_vec[EV_HOME]   = edge_rise[1];
    evt_vec[EV_STALL]  = wd_expire;
  end

  enc_evt_status #(.NE(NUM_EVT), .NL(N_LEVEL)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_vec),
    .clr_wr_i   (clr_wr_i),
    .clr_bits_i (clr_data_i),
    .lvl_mask_i ({trg_mask_i, dma_mask_i, irq_mask_i}),
    .rd_mask_i  (rd_mask_i),
    .st_o       (st_vec),
    .lvl_o      (lvl),
    .rd_pulse_o (rd_load_o)
  );

  assign status_o  = {st_vec, {LOW_W{1'b0}}};
  assign irq_o     = lvl[0];
  assign dma_req_o = lvl[1];
  assign trig_o    = lvl[2];
endmodule

// File: rtl/enc_event_unit_chk.sv
module enc_event_unit_chk #(
  parameter int TO_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            home_i,
  input logic            z_index_i,
  input logic            clr_wr_i,
  input logic [31:28]    clr_data_i,
  input logic [TO_W-1:0] wdg_timeout_i,
  input logic [31:0]     status_o,
  input logic [3:0]      evt,
  input logic            wd_evt
);
  p_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[27:0] == 28'd0);

  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i && clr_data_i[31] && !evt[3] |=> !status_o[31]);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[30] && !(clr_wr_i && clr_data_i[30]) |=> status_o[30]);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 4'd0) |=> ((status_o[31:28] & $past(evt)) == $past(evt)));

  p_stall_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_evt |=> (!wd_evt || !$stable(wdg_timeout_i)));

  p_home_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(home_i) |=> status_o[30]);

  p_zidx_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_index_i) |=> status_o[28]);
endmodule

bind enc_event_unit enc_event_unit_chk #(.TO_W(TO_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .home_i        (home_i),
  .z_index_i     (z_index_i),
  .clr_wr_i      (clr_wr_i),
  .clr_data_i    (clr_data_i),
  .wdg_timeout_i (wdg_timeout_i),
  .status_o      (status_o),
  .evt           (evt_vec),
  .wd_evt        (wd_expire)
);

// File: tb/tb_enc_event_unit.sv
`timescale 1ns/1ps
module tb_enc_event_unit;
  localparam int PH_W = 16, Z_W = 16, TO_W = 16;
  localparam logic [15:0] PCMP = 16'd100, ZCMP = 16'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PH_W-1:0] ph_cnt = PCMP + 16'd5;
  logic [Z_W-1:0]  z_cnt = ZCMP;
  logic step = 0, dir = 0, home = 0, zidx = 0;
  logic zdis = 1, dreq = 0, ddis = 1, wen = 0;
  logic [TO_W-1:0] wto = 0;
  logic clr_wr = 0;
  logic [3:0] clr_d = 0, irqm = 0, dmam = 0, trgm = 0, rdm = 0;
  logic [31:0] status;
  logic irq, dma, trig, rdl;
  int vecs = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  enc_event_unit #(.PH_W(PH_W), .Z_W(Z_W), .TO_W(TO_W)) dut (
    .clk(clk), .rst_n(rst_n), .ph_cnt_i(ph_cnt), .z_cnt_i(z_cnt),
    .cnt_step_i(step), .dir_i(dir), .home_i(home), .z_index_i(zidx),
    .ph_cmp_i(PCMP), .z_cmp_i(ZCMP), .z_cmp_dis_i(zdis), .dir_req_i(dreq),
    .dir_dis_i(ddis), .wdg_en_i(wen), .wdg_timeout_i(wto),
    .clr_wr_i(clr_wr), .clr_data_i(clr_d), .irq_mask_i(irqm),
    .dma_mask_i(dmam), .trg_mask_i(trgm), .rd_mask_i(rdm),
    .status_o(status), .irq_o(irq), .dma_req_o(dma), .trig_o(trig),
    .rd_load_o(rdl));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear(input logic [3:0] bits);
    clr_wr = 1; clr_d = bits; tick(); clr_wr = 0; clr_d = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  // raise all four events; stall timeout 2
  task automatic raise_all();
    home = 1; zidx = 1; ph_cnt = PCMP; zdis = 1; ddis = 1;
    step = 1; wen = 1; wto = 2;
    tick();
    home = 0; zidx = 0; ph_cnt = PCMP + 16'd5; step = 0;
    tick(); tick(); tick();
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset status", status, 32'h0);
    chk("R1 reset outputs", {irq, dma, trig, rdl}, 0);
    rst_n = 1;
    tick();
    chk("R1 idle status", status, 32'h0);

    // R9 home and index edges; level held gives no repeat
    home = 1; tick();
    chk("R9 home sets bit30", status, 32'h4000_0000);
    clear(4'b0100);
    chk("R9 held home no repeat", status, 32'h0);
    home = 0; zidx = 1; tick();
    chk("R9 index sets bit28", status, 32'h1000_0000);
    zidx = 0; tick();

    // R2 write 0 keeps, write 1 clears
    clear(4'b0100);
    chk("R2 zero bit keeps", status, 32'h1000_0000);
    clear(4'b0001);
    chk("R2 one bit clears", status, 32'h0);

    // R3 event and clear in same cycle
    zidx = 1; clr_wr = 1; clr_d = 4'b0001; tick();
    clr_wr = 0; clr_d = 0; zidx = 0;
    chk("R3 set wins over clear", status, 32'h1000_0000);
    clear(4'b1111);

    // R5 read-load strobe
    rdm = 4'b0100;
    home = 1; tick();
    chk("R5 pulse on enabled event", rdl, 1);
    home = 0; tick();
    chk("R5 pulse lasts one cycle", rdl, 0);
    zidx = 1; tick();
    chk("R5 no pulse for masked event", rdl, 0);
    zidx = 0; tick();
    home = 1; tick();
    chk("R5 pulse with bit already set", rdl, 1);
    home = 0; tick();
    rdm = 0;
    clear(4'b1111);

    // R6/R7 sweep of match conditions
    for (int d = -1; d <= 1; d++)
      for (int zm = 0; zm < 2; zm++)
        for (int zd = 0; zd < 2; zd++)
          for (int dv = 0; dv < 2; dv++)
            for (int rq = 0; rq < 2; rq++)
              for (int dd = 0; dd < 2; dd++) begin
                ph_cnt = PCMP + 16'd5; clr_wr = 1; clr_d = 4'b0010; tick();
                clr_wr = 0; clr_d = 0;
                ph_cnt = PCMP + 16'(d);
                z_cnt  = zm ? ZCMP : ZCMP + 16'd1;
                zdis = zd[0]; dir = dv[0]; dreq = rq[0]; ddis = dd[0];
                tick();
                chk("R6 R7 match sweep", status[29],
                    (d == 0) && (zd || zm) && (dd || dv == rq));
              end
    // R6 once per entry: condition held after clear
    ph_cnt = PCMP; z_cnt = ZCMP; zdis = 0; ddis = 1; tick();
    clear(4'b0010);
    tick();
    chk("R6 held match no refire", status[29], 0);
    ph_cnt = PCMP + 16'd5; zdis = 1; tick();
    clear(4'b1111);

    // R8 stall timing sweep
    for (int t = 1; t <= 6; t++) begin
      wen = 1; wto = 16'(t); step = 1; clr_wr = 1; clr_d = 4'b1000; tick();
      step = 0; clr_wr = 0; clr_d = 0;
      for (int k = 1; k <= t + 2; k++) begin
        tick();
        chk("R8 stall after T edges", status[31], k >= t);
      end
      clear(4'b1000);
      tick(); tick(); tick();
      chk("R8 fires once", status[31], 0);
    end
    wto = 0; step = 1; tick(); step = 0;
    for (int k = 0; k < 10; k++) tick();
    chk("R8 timeout zero never", status[31], 0);
    wen = 0; wto = 2; step = 1; tick(); step = 0;
    for (int k = 0; k < 10; k++) tick();
    chk("R8 disabled never", status[31], 0);

    // R4 every status pattern crossed with every mask
    for (int s = 0; s < 16; s++) begin
      raise_all();
      clear(~4'(s));
      chk("R4 status pattern", status, {4'(s), 28'd0});
      for (int m = 0; m < 16; m++) begin
        irqm = 4'(m); dmam = ~4'(m); trgm = 4'(m) ^ 4'(s);
        #1;
        chk("R4 irq", irq, (s & m) != 0);
        chk("R4 dma", dma, (s & ~m & 15) != 0);
        chk("R4 trig", trig, (s & (m ^ s)) != 0);
        @(negedge clk);
      end
      irqm = 0; dmam = 0; trgm = 0;
    end
    finish_run();
  end
endmodule